// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by walking a multi-level radix page tree in memory. A request carries the effective address, a store flag, an instruction-fetch flag, a privilege flag, the process ID and the process-table base register. The walker first reads the process-table entry for the effective process, checks the segment and the tree configuration, and then reads one directory entry per level until it reaches a leaf. Each level's index width comes from the size field of the entry that points to it.

All reads go through one 64-bit single-beat read port, with one read outstanding at a time. Each request ends with exactly one `done` pulse that carries a status code and, on success, the real address. A translation cache or a load/store unit sits around the walker and owns the retry and fault-reporting policy.

Bits below are numbered LSB-first: bit 63 is the most significant bit of a word.

Top module: `radix_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, `req_ready` is 1, `mem_req` is 0 and `done` is 0.
- R2: The process-table entry address is `{8'h0, ptab[55:36], (ptab[35:12] & ~m) | (pid[31:8] & m), pid[7:0], 4'h0}`. Here `m` holds the low `ptab[4:0]` bits set, capped at 24 bits. PID bits that `m` does not select have no effect on the address.
- R3: When `req_ea[63]` is 1, the effective PID is zero and `req_pid` has no effect.
- R4: The walk ends with status 1 (segment error) after the process-table read in two cases: when `req_ea[63]` differs from `req_ea[62]`, or when any bit of `req_ea[61:31]` at or above position 31+tree size is set. The tree size is `{0, e[7:5], e[62:61]}` of the entry.
- R5: The root size is `e[4:0]` of the process-table entry. If it is below 5, above 16, or above tree size + 19, the walk ends with status 2 (bad tree). Otherwise the shift becomes tree size + 19 - root size, the directory base becomes `{8'h0, e[55:8], 8'h0}`, and the walk continues.
- R6: Each directory read goes to `{8'h0, base[55:19], (base[18:3] & ~k) | (idx & k), 3'b0}`. Here `idx` is `ea[61:12] >> shift` and `k` holds the low current-size bits set. A 4-level walk makes exactly 5 reads.
- R7: A valid non-leaf entry (bit 63 = 1, bit 62 = 0) whose size field `e[4:0]` is below 5, above 16, or above the current shift ends the walk with status 2. Otherwise the shift drops by that size and the walk goes down one level.
- R8: An entry with bit 63 clear ends the walk with status 3 (no PTE).
- R9: The leaf permission check uses the access-authority bits in `e[3:0]`: bit 3 means privileged only, bit 2 read, bit 1 read/write, bit 0 execute. The attribute field is `e[5:4]`, and `e[5]` = 1 marks the page as cache-inhibited. Permission is granted only if the request is privileged or bit 3 is clear. A data access also needs bit 1, or bit 2 without a store. A fetch also needs bit 0 with the page not cache-inhibited. Failure gives status 4.
- R10: The reference bit is `e[8]` and the change bit is `e[7]`. The reference/change check needs `e[8]`, and for a store also `e[7]`. It fails with status 5, but only when the permission check passed: status 4 takes precedence.
- R11: On status 0 (ok), `real_addr = {8'h0, (e[55:12] & ~f) | (ea[55:12] & f), ea[11:0]}`, where `f` holds the low final-shift bits set, so large pages take more bits from the effective address.
- R12: Each request yields exactly one single-cycle `done`. `real_addr` is zero unless the status is 0. `mem_req` and `mem_addr` hold steady until `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken while `req_ready`) |
| req_ready | output | 1 | Walker idle |
| req_ea | input | 64 | Effective address |
| req_store | input | 1 | Access is a store |
| req_ifetch | input | 1 | Access is an instruction fetch |
| req_priv | input | 1 | Access is privileged |
| req_pid | input | 32 | Process ID |
| req_ptab | input | 64 | Process-table base and size (`[4:0]`) |
| mem_req | output | 1 | Read request, held until `mem_valid` |
| mem_addr | output | 64 | Doubleword read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| status | output | 3 | 0 ok, 1 segment, 2 bad tree, 3 no PTE, 4 permission, 5 ref/change |
| real_addr | output | 64 | Translated address, zero unless ok |

## Verification
A wrong shift or size register shows up on the very next read address: the bench's memory image holds the entries only at the expected locations. A stray index therefore reads zero and ends the walk within one read with a no-PTE status. A stale directory base or a mis-latched flag shows up at `done` as a wrong status or address, a few cycles after the leaf read. The leaf check is swept over every combination of authority bits, cache inhibit, reference, change, store, fetch and privilege, so any mistake in fault precedence shows up as a wrong status code.

// File: rtl/radix_walk_pkg.sv
// Package: shared widths, status codes and walker states.
// Assumes 64-bit table entries and a 32-bit process ID.
package radix_walk_pkg;
    localparam int WORD_W       = 64;
    localparam int PID_W        = 32;
    localparam int SHIFT_W      = 7;
    localparam int MIN_LVL_BITS = 5;
    localparam int MAX_LVL_BITS = 16;
    localparam int TREE_BIAS    = 19;

    typedef enum logic [2:0] {
        WS_OK      = 3'd0,
        WS_SEG     = 3'd1,
        WS_BADTREE = 3'd2,
        WS_NOPTE   = 3'd3,
        WS_PERM    = 3'd4,
        WS_RC      = 3'd5
    } walk_status_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRT,
        ST_DIR,
        ST_FIN
    } walk_state_e;
endpackage

// File: rtl/rw_ptab_addr.sv
// Forms the process-table entry address from the table base register,
// the effective PID and the quadrant bit. Assumes 16-byte entries and a
// size field in base[4:0] that selects how many PID bits replace base bits.
module rw_ptab_addr
    import radix_walk_pkg::*;
(
    input  logic [WORD_W-1:0] ptab_base,
    input  logic              quad3,
    input  logic [PID_W-1:0]  pid,
    output logic [WORD_W-1:0] addr
);
    localparam int MID_W = 24;

    logic [PID_W-1:0] eff_pid;
    logic [MID_W-1:0] mid_mask;
    logic             unused_ptab;

    // Kernel quadrant always indexes entry zero
    assign eff_pid  = quad3 ? '0 : pid;
    // Low size-field bits of the middle slice come from the PID
    assign mid_mask = (ptab_base[4:0] >= 5'(MID_W)) ? '1
                    : ((MID_W'(1) << ptab_base[4:0]) - MID_W'(1));
    assign addr = {8'h0, ptab_base[55:36],
                   (ptab_base[35:12] & ~mid_mask) | (eff_pid[31:8] & mid_mask),
                   eff_pid[7:0], 4'h0};
    assign unused_ptab = ^{ptab_base[63:56], ptab_base[11:5]};
endmodule

// File: rtl/rw_dir_addr.sv
// Forms a directory entry address from the level base, the effective
// address, the current shift and the level size. Assumes size <= 16.
module rw_dir_addr
    import radix_walk_pkg::*;
(
    input  logic [WORD_W-1:0]  base,
    input  logic [WORD_W-1:0]  ea,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [4:0]         lvl_size,
    output logic [WORD_W-1:0]  addr
);
    logic [49:0] ea_sh;
    logic [16:0] idx_mask;
    logic        unused_dir;

    // Index bits for this level sit just above the current shift
    assign ea_sh    = ea[61:12] >> shift;
    assign idx_mask = (17'd1 << lvl_size) - 17'd1;
    assign addr = {8'h0, base[55:19],
                   (base[18:3] & ~idx_mask[15:0]) | (ea_sh[15:0] & idx_mask[15:0]),
                   3'b000};
    assign unused_dir = ^{base[63:56], base[2:0], ea[63:62], ea[11:0],
                          ea_sh[49:16], idx_mask[16]};
endmodule

// File: rtl/rw_leaf_check.sv
// Checks a leaf entry's access authority and reference/change bits and
// forms the real address. Permission failure outranks a ref/change failure.
module rw_leaf_check
    import radix_walk_pkg::*;
(
    input  logic [WORD_W-1:0]  pte,
    input  logic [WORD_W-1:0]  ea,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               is_store,
    input  logic               is_ifetch,
    input  logic               is_priv,
    output walk_status_e       leaf_status,
    output logic [WORD_W-1:0]  leaf_ra
);
    logic        perm_ok;
    logic        rc_ok;
    logic [43:0] fin_mask;
    logic        unused_leaf;

    // Authority: privilege gate, then data or fetch rights
    assign perm_ok = (is_priv || !pte[3]) &&
                     (is_ifetch ? (pte[0] && !pte[5])
                                : (pte[1] || (pte[2] && !is_store)));
    // Reference always, change only for stores
    assign rc_ok   = pte[8] && (pte[7] || !is_store);

    // Fixed precedence of leaf faults
    always_comb begin
        if (!perm_ok)    leaf_status = WS_PERM;
        else if (!rc_ok) leaf_status = WS_RC;
        else             leaf_status = WS_OK;
    end

    // Page bits below the final shift come from the effective address
    assign fin_mask = (44'd1 << shift) - 44'd1;
    assign leaf_ra  = {8'h0, (pte[55:12] & ~fin_mask) | (ea[55:12] & fin_mask), ea[11:0]};
    assign unused_leaf = ^{pte[63:56], pte[11:9], pte[6], pte[4], ea[63:56]};
endmodule

// File: rtl/radix_walker.sv
// Radix tree walker: reads the process-table entry, validates segment and
// tree size, walks directory levels, checks the leaf. One read in flight;
// memory must return each read with mem_valid for one cycle.
module radix_walker
    import radix_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_ea,
    input  logic              req_store,
    input  logic              req_ifetch,
    input  logic              req_priv,
    input  logic [31:0]       req_pid,
    input  logic [63:0]       req_ptab,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_valid,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic [2:0]        status,
    output logic [63:0]       real_addr
);
    localparam logic [5:0]         MIN6 = 6'(MIN_LVL_BITS);
    localparam logic [5:0]         MAX6 = 6'(MAX_LVL_BITS);
    localparam logic [SHIFT_W-1:0] MINS = SHIFT_W'(MIN_LVL_BITS);
    localparam logic [SHIFT_W-1:0] MAXS = SHIFT_W'(MAX_LVL_BITS);

    walk_state_e        state;
    walk_status_e       status_q;
    logic [WORD_W-1:0]  ea_q, ptab_q, base_q, ra_q;
    logic [PID_W-1:0]   pid_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [4:0]         size_q;
    logic               store_q, ifetch_q, priv_q;

    logic [WORD_W-1:0]  prt_addr, dir_addr, leaf_ra;
    walk_status_e       leaf_status;
    logic [5:0]         tree_sz, root_sz;
    logic [30:0]        seg_mask;
    logic [SHIFT_W-1:0] tree_lim, nls;
    logic               seg_bad, root_bad, dir_bad;

    rw_ptab_addr u_ptab (.ptab_base(ptab_q), .quad3(ea_q[63]), .pid(pid_q), .addr(prt_addr));
    rw_dir_addr  u_dir  (.base(base_q), .ea(ea_q), .shift(shift_q), .lvl_size(size_q),
                         .addr(dir_addr));
    rw_leaf_check u_leaf (.pte(mem_rdata), .ea(ea_q), .shift(shift_q), .is_store(store_q),
                          .is_ifetch(ifetch_q), .is_priv(priv_q),
                          .leaf_status(leaf_status), .leaf_ra(leaf_ra));

    // Process-table entry decode and segment / tree-size checks
    assign tree_sz  = {1'b0, mem_rdata[7:5], mem_rdata[62:61]};
    assign root_sz  = {1'b0, mem_rdata[4:0]};
    assign seg_mask = (31'd1 << tree_sz) - 31'd1;
    assign seg_bad  = (ea_q[63] ^ ea_q[62]) | (|(ea_q[61:31] & ~seg_mask));
    assign tree_lim = SHIFT_W'(tree_sz) + SHIFT_W'(TREE_BIAS);
    assign root_bad = (root_sz < MIN6) || (root_sz > MAX6) || (SHIFT_W'(root_sz) > tree_lim);
    // Non-leaf size check against the remaining shift
    assign nls      = SHIFT_W'(mem_rdata[4:0]);
    assign dir_bad  = (nls < MINS) || (nls > MAXS) || (nls > shift_q);

    // Walk state machine and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            status_q <= WS_OK;
            ra_q     <= '0;
            ea_q     <= '0;
            ptab_q   <= '0;
            pid_q    <= '0;
            base_q   <= '0;
            shift_q  <= '0;
            size_q   <= '0;
            store_q  <= 1'b0;
            ifetch_q <= 1'b0;
            priv_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    ea_q     <= req_ea;
                    ptab_q   <= req_ptab;
                    pid_q    <= req_pid;
                    store_q  <= req_store;
                    ifetch_q <= req_ifetch;
                    priv_q   <= req_priv;
                    status_q <= WS_OK;
                    ra_q     <= '0;
                    state    <= ST_PRT;
                end
                ST_PRT: if (mem_valid) begin
                    if (seg_bad) begin
                        status_q <= WS_SEG;
                        state    <= ST_FIN;
                    end else if (root_bad) begin
                        status_q <= WS_BADTREE;
                        state    <= ST_FIN;
                    end else begin
                        shift_q <= tree_lim - SHIFT_W'(root_sz);
                        size_q  <= root_sz[4:0];
                        base_q  <= {8'h0, mem_rdata[55:8], 8'h0};
                        state   <= ST_DIR;
                    end
                end
                ST_DIR: if (mem_valid) begin
                    if (!mem_rdata[63]) begin
                        status_q <= WS_NOPTE;
                        state    <= ST_FIN;
                    end else if (mem_rdata[62]) begin
                        status_q <= leaf_status;
                        ra_q     <= (leaf_status == WS_OK) ? leaf_ra : '0;
                        state    <= ST_FIN;
                    end else if (dir_bad) begin
                        status_q <= WS_BADTREE;
                        state    <= ST_FIN;
                    end else begin
                        shift_q <= shift_q - nls;
                        size_q  <= mem_rdata[4:0];
                        base_q  <= {8'h0, mem_rdata[55:8], 8'h0};
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port views of the state
    assign req_ready = (state == ST_IDLE);
    assign mem_req   = (state == ST_PRT) || (state == ST_DIR);
    assign mem_addr  = (state == ST_PRT) ? prt_addr : dir_addr;
    assign done      = (state == ST_FIN);
    assign status    = status_q;
    assign real_addr = ra_q;
endmodule

// File: rtl/radix_walker_chk.sv
// Protocol checker for radix_walker, bound to every instance.
module radix_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req,
    input logic [63:0] mem_addr,
    input logic        mem_valid,
    input logic        done,
    input logic [2:0]  status,
    input logic [63:0] real_addr
);
    // R1: idle means no read and no completion
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done));

    // R6: reads are doubleword aligned inside the 56-bit real space
    p_addr_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000 && mem_addr[63:56] == 8'h00));

    // R12: an unanswered read holds its request and address
    p_hold_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R12: completion lasts one cycle
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: failed walks report no address
    p_ra_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 3'd0) |-> (real_addr == 64'h0));

    // R12: status codes stay within the defined set
    p_status_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status <= 3'd5));
endmodule

bind radix_walker radix_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .done(done),
    .status(status), .real_addr(real_addr)
);

// File: tb/radix_walker_tb.sv
`timescale 1ns/1ps
module radix_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ea = '0;
    logic        req_store = 1'b0, req_ifetch = 1'b0, req_priv = 1'b0;
    logic [31:0] req_pid = '0;
    logic [63:0] req_ptab = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [2:0]  status;
    logic [63:0] real_addr;

    always #2.5 clk = ~clk;

    radix_walker u_dut (.*);

    logic [63:0] mem_img [logic [63:0]];
    int n_chk = 0, n_bad = 0, n_reads = 0;
    logic [2:0]  got_st;
    logic [63:0] got_ra;
    int          got_reads;
    logic [63:0] leaf_a;

    localparam logic [63:0] PTAB = 64'h0000_0000_0001_0000;
    localparam logic [63:0] EA0  = 64'h000F_EDCB_A987_6543;
    localparam logic [63:0] RPN  = 64'h00AB_CDEF_1234_5000;

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req && !mem_valid) begin
            mem_valid <= 1'b1;
            mem_rdata <= mem_img.exists(mem_addr) ? mem_img[mem_addr] : 64'h0;
            n_reads   <= n_reads + 1;
        end else begin
            mem_valid <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] prt_addr(input logic [31:0] pid, input logic [63:0] pt);
        logic [23:0] m;
        m = (pt[4:0] >= 5'd24) ? '1 : ((24'd1 << pt[4:0]) - 24'd1);
        return {8'h0, pt[55:36], (pt[35:12] & ~m) | (pid[31:8] & m), pid[7:0], 4'h0};
    endfunction

    function automatic logic [63:0] prte(input logic [5:0] rts, input logic [63:0] base,
                                         input logic [4:0] sz);
        logic [63:0] e = '0;
        e[62:61] = rts[1:0];
        e[7:5]   = rts[4:2];
        e[55:8]  = base[55:8];
        e[4:0]   = sz;
        return e;
    endfunction

    function automatic logic [63:0] dirw(input logic v, input logic [63:0] nb, input logic [4:0] sz);
        logic [63:0] e = '0;
        e[63]   = v;
        e[55:8] = nb[55:8];
        e[4:0]  = sz;
        return e;
    endfunction

    function automatic logic [63:0] leafw(input logic v, input logic [63:0] pg, input logic r,
                                          input logic c, input logic [1:0] att, input logic [3:0] eaa);
        logic [63:0] e = '0;
        e[63]    = v;
        e[62]    = 1'b1;
        e[55:12] = pg[55:12];
        e[8]     = r;
        e[7]     = c;
        e[5:4]   = att;
        e[3:0]   = eaa;
        return e;
    endfunction

    function automatic logic [63:0] exp_ra(input logic [63:0] pg, input logic [63:0] ea, input int lowb);
        logic [63:0] m = (64'd1 << lowb) - 64'd1;
        return ((pg & ~m) | (ea & m)) & 64'h00FF_FFFF_FFFF_FFFF;
    endfunction

    // Four-level tree: root 13 bits, then 9/9/9; shifts 27,18,9,0
    task automatic build_tree(input logic [63:0] ea, input logic [31:0] pid, input logic [63:0] pt);
        mem_img[prt_addr(pid, pt)] = prte(6'd21, 64'h20000, 5'd13);
        mem_img[64'h20000 + 8 * ((ea >> 39) & 64'h1FFF)] = dirw(1'b1, 64'h40000, 5'd9);
        mem_img[64'h40000 + 8 * ((ea >> 30) & 64'h1FF)]  = dirw(1'b1, 64'h50000, 5'd9);
        mem_img[64'h50000 + 8 * ((ea >> 21) & 64'h1FF)]  = dirw(1'b1, 64'h60000, 5'd9);
        leaf_a = 64'h60000 + 8 * ((ea >> 12) & 64'h1FF);
    endtask

    task automatic run(input logic [63:0] ea, input logic st, input logic ifc, input logic pv,
                       input logic [31:0] pid, input logic [63:0] pt);
        int r0, w;
        @(negedge clk);
        req_ea = ea; req_store = st; req_ifetch = ifc; req_priv = pv;
        req_pid = pid; req_ptab = pt; req_valid = 1'b1;
        r0 = n_reads;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!done && w < 300) begin
            @(negedge clk);
            w++;
        end
        if (!done) begin
            got_st = 3'd7; got_ra = '1; got_reads = -1;
            chk("R12 done seen", 64'd0, 64'd1);
        end else begin
            got_st = status; got_ra = real_addr; got_reads = n_reads - r0;
            @(negedge clk);
            chk("R12 single done", 64'(done), 64'd0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R12 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 mem_req", 64'(mem_req), 64'd0);
        chk("R1 done", 64'(done), 64'd0);

        // R6 R11 basic 4-level load
        build_tree(EA0, 32'd3, PTAB);
        mem_img[leaf_a] = leafw(1'b1, RPN, 1'b1, 1'b1, 2'b00, 4'b0110);
        run(EA0, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
        chk("R6 status", 64'(got_st), 64'd0);
        chk("R11 ra 4k", got_ra, exp_ra(RPN, EA0, 12));
        chk("R6 reads", 64'(got_reads), 64'd5);
        chk("R1 idle after", 64'(req_ready), 64'd1);

        // R2 PID bits above the mask are ignored with size 0
        run(EA0, 1'b1, 1'b0, 1'b0, 32'h103, PTAB);
        chk("R2 pid high ignored st", 64'(got_st), 64'd0);
        chk("R2 pid high ignored ra", got_ra, exp_ra(RPN, EA0, 12));

        // R2 size 1 pulls pid[8] into base bit 12: empty entry first
        run(EA0, 1'b0, 1'b0, 1'b1, 32'h103, PTAB | 64'd1);
        chk("R2 size1 empty entry", 64'(got_st), 64'd1);
        mem_img[64'h11030] = prte(6'd21, 64'h20000, 5'd13);
        run(EA0, 1'b0, 1'b0, 1'b1, 32'h103, PTAB | 64'd1);
        chk("R2 size1 entry", 64'(got_st), 64'd0);

        // R3 R11 kernel quadrant uses PID 0 tree with a leaf at level 1
        begin
            logic [63:0] ea3 = 64'hC00F_EDCB_A987_6543;
            logic [63:0] big = 64'h0000_0123_8000_0000;
            mem_img[prt_addr(32'd0, PTAB)] = prte(6'd21, 64'h30000, 5'd13);
            mem_img[64'h30000 + 8 * ((ea3 >> 39) & 64'h1FFF)] =
                leafw(1'b1, big, 1'b1, 1'b1, 2'b00, 4'b0110);
            run(ea3, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
            chk("R3 status", 64'(got_st), 64'd0);
            chk("R3 reads", 64'(got_reads), 64'd2);
            chk("R11 ra large", got_ra, exp_ra(big, ea3, 39));
        end

        // R11 leaf at level 3 (2 MB page)
        begin
            logic [63:0] l3a = 64'h50000 + 8 * ((EA0 >> 21) & 64'h1FF);
            logic [63:0] mid = 64'h0000_0456_7800_0000;
            logic [63:0] keep = mem_img[l3a];
            mem_img[l3a] = leafw(1'b1, mid, 1'b1, 1'b1, 2'b00, 4'b0010);
            run(EA0, 1'b1, 1'b0, 1'b1, 32'd3, PTAB);
            chk("R11 2m status", 64'(got_st), 64'd0);
            chk("R11 2m ra", got_ra, exp_ra(mid, EA0, 21));
            chk("R6 2m reads", 64'(got_reads), 64'd4);
            mem_img[l3a] = keep;
        end

        // R4 segment errors
        run(64'h800F_EDCB_A987_6543, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
        chk("R4 quadrant 2", 64'(got_st), 64'd1);
        chk("R4 reads", 64'(got_reads), 64'd1);
        run(64'h400F_EDCB_A987_6543, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
        chk("R4 quadrant 1", 64'(got_st), 64'd1);
        run(64'h001F_EDCB_A987_6543, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
        chk("R4 bit above tree", 64'(got_st), 64'd1);
        chk("R12 ra zero on error", got_ra, 64'd0);

        // R5 bad root sizes
        mem_img[prt_addr(32'd5, PTAB)] = prte(6'd21, 64'h20000, 5'd4);
        run(EA0, 1'b0, 1'b0, 1'b1, 32'd5, PTAB);
        chk("R5 root 4", 64'(got_st), 64'd2);
        mem_img[prt_addr(32'd5, PTAB)] = prte(6'd21, 64'h20000, 5'd17);
        run(EA0, 1'b0, 1'b0, 1'b1, 32'd5, PTAB);
        chk("R5 root 17", 64'(got_st), 64'd2);

        // R7 bad non-leaf sizes
        begin
            logic [63:0] l2a = 64'h40000 + 8 * ((EA0 >> 30) & 64'h1FF);
            logic [63:0] l3a = 64'h50000 + 8 * ((EA0 >> 21) & 64'h1FF);
            mem_img[l2a] = dirw(1'b1, 64'h50000, 5'd4);
            run(EA0, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
            chk("R7 size 4", 64'(got_st), 64'd2);
            mem_img[l2a] = dirw(1'b1, 64'h50000, 5'd17);
            run(EA0, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
            chk("R7 size 17", 64'(got_st), 64'd2);
            mem_img[l2a] = dirw(1'b1, 64'h50000, 5'd9);
            mem_img[l3a] = dirw(1'b1, 64'h60000, 5'd10);
            run(EA0, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
            chk("R7 size over shift", 64'(got_st), 64'd2);
            mem_img[l3a] = dirw(1'b1, 64'h60000, 5'd9);

            // R8 invalid entries
            mem_img[leaf_a] = leafw(1'b0, RPN, 1'b1, 1'b1, 2'b00, 4'b0110);
            run(EA0, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
            chk("R8 invalid leaf", 64'(got_st), 64'd3);
            mem_img[l2a] = dirw(1'b0, 64'h50000, 5'd9);
            run(EA0, 1'b0, 1'b0, 1'b1, 32'd3, PTAB);
            chk("R8 invalid dir", 64'(got_st), 64'd3);
            chk("R8 reads", 64'(got_reads), 64'd3);
            mem_img[l2a] = dirw(1'b1, 64'h50000, 5'd9);
        end

        // R10 precedence: no rights and no reference gives permission error
        mem_img[leaf_a] = leafw(1'b1, RPN, 1'b0, 1'b0, 2'b00, 4'b0000);
        run(EA0, 1'b1, 1'b0, 1'b1, 32'd3, PTAB);
        chk("R10 precedence", 64'(got_st), 64'd4);

        // R9 R10 exhaustive leaf sweep
        for (int k = 0; k < 1024; k++) begin
            logic [3:0] eaa = k[3:0];
            logic ci = k[4], rf = k[5], ch = k[6], st = k[7], fe = k[8], pv = k[9];
            logic perm, rc;
            logic [2:0] est;
            perm = (pv || !eaa[3]) && (fe ? (eaa[0] && !ci) : (eaa[1] || (eaa[2] && !st)));
            rc   = rf && (ch || !st);
            est  = !perm ? 3'd4 : (!rc ? 3'd5 : 3'd0);
            mem_img[leaf_a] = leafw(1'b1, RPN, rf, ch, ci ? 2'b10 : 2'b00, eaa);
            run(EA0, st, fe, pv, 32'd3, PTAB);
            chk($sformatf("R9 R10 sweep %0d status", k), 64'(got_st), 64'(est));
            chk($sformatf("R11 sweep %0d ra", k), got_ra,
                (est == 3'd0) ? exp_ra(RPN, EA0, 12) : 64'd0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule